// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave model of a byte-wide serial memory on a two-wire bus. It is built for 256 bytes, and one parameter cuts it to 128 bytes. The clock line and the data line arrive as separate inputs. A fast system clock oversamples both of them. The block answers by raising an open-drain enable that pulls the data line low. Each input line passes through a digital spike filter. After the filter, edge logic finds START and STOP conditions and the clock edges, and a byte-level state machine decodes the control byte, the word address and the data bytes.

A write collects its data bytes in a page latch. The latch holds 8 bytes and wraps inside the page. Its contents reach the register array only when a STOP arrives. A self-timed busy window then follows. While that window is open, the slave refuses its control byte, so a master can poll until the write is done.

Reads can continue from the internal address pointer (current-address read), or they can begin after a dummy write that sets the pointer and a repeated START (random read). A read may run on through sequential bytes. Whenever the slave drives the data line, it holds back each change for a set number of system clocks after the clock line falls.

Top module: `seep_slave`

## Requirements
- R1: After reset the data-line enable `sda_oe_o` is low and the slave is not busy, so its first control byte is acknowledged.
- R2: A pulse of the data or clock line that lasts fewer than FILT_CLKS system clocks is ignored. A low glitch on SDA while SCL is high neither starts nor stops a transfer.
- R3: A control byte whose upper four bits are 1010 is acknowledged by pulling SDA low on the ninth clock, whatever its bits 3..1 hold. Bit 0 selects the direction: 1 is read, 0 is write. Any other control byte is not acknowledged, and the slave stays silent until the next START.
- R4: A write with one data byte stores that byte at the given word address, and a random read returns it afterwards.
- R5: Successive write data bytes go to addresses whose low 3 bits count up and wrap inside the 8-byte page. When more than 8 bytes arrive, the later bytes overwrite the earlier ones.
- R6: Write data is committed only on STOP. A repeated START that comes before a STOP discards the staged bytes. After a committing STOP, control bytes are not acknowledged for BUSY_CLKS system clocks.
- R7: A STOP that follows only the control and address bytes commits nothing and starts no busy window.
- R8: A read advances the full address after each byte and wraps from the top address to 0. A current-address read continues from the address that follows the last byte read.
- R9: The slave changes `sda_oe_o` no sooner than HOLD_CLKS system clocks after SCL falls, and never while SCL is high.
- R10: With MEM_BYTES = 128, the address MSB is ignored, so a write to address 0x85 can be read back at address 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_oe_o | output | 1 | When high, pulls the data line low (open drain) |

## Verification
The hardest case to reach from the ports is a page write that overruns the latch. The bench writes 10 bytes starting at offset 5 of a page, so the index wraps and overwrites, and it predicts the final contents of the page by applying the same writes in order to its own model. A second hard case is a write cut off by a repeated START. The bench stages a byte, restarts without a STOP, and reads the location back to show the old value is still there. It also polls at once to show that no busy window was opened. A two-cycle SDA glitch during a clock-high phase tests the filter, and a read that starts two bytes below the top address crosses the wrap at 0.

// File: rtl/seep_pkg.sv
package seep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_CTRL_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
  } seep_state_e;

  localparam logic [3:0] SEEP_DEV_ID = 4'b1010;
endpackage

// File: rtl/seep_filter.sv
module seep_filter #(
  parameter int FILT_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CLKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != filt_q) begin
        if (cnt_q == CW'(FILT_CLKS - 1)) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign filt_o = filt_q;

  // R2
  filt_follows_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> filt_q == $past(sync_q[1]));
endmodule

// File: rtl/seep_page_latch.sv
module seep_page_latch #(
  parameter int PAGE_BYTES = 8,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  wr_i,
  input  logic [PW-1:0]         idx_i,
  input  logic [7:0]            data_i,
  output logic [7:0]            data_o [PAGE_BYTES],
  output logic [PAGE_BYTES-1:0] valid_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (clear_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_i && idx_i == PW'(g)) begin
        data_q[g]  <= data_i;
        valid_q[g] <= 1'b1;
      end
    end
    assign data_o[g] = data_q[g];
  end

  assign valid_o = valid_q;

  // R6
  latch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> valid_o == '0);
  // R5
  latch_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clear_i |=> valid_o[$past(idx_i)]);
endmodule

// File: rtl/seep_busy_timer.sv
module seep_busy_timer #(
  parameter int BUSY_CLKS = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CLKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(BUSY_CLKS);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R6
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R6
  busy_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start_i |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/seep_slave.sv
module seep_slave
  import seep_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int FILT_CLKS  = 3,
  parameter int HOLD_CLKS  = 16,
  parameter int BUSY_CLKS  = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = $clog2(HOLD_CLKS + 1);

  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    seep_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .filt_o(filt[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;

  seep_state_e   state_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q, tx_q;
  logic [AW-1:0] addr_q;
  logic          rw_q, mack_q, pend_q, oe_q;
  logic [HW-1:0] hold_q;
  logic          busy;

  logic [7:0]            lat_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] lat_valid;
  logic                  lat_wr, lat_clear, commit;
  logic [7:0]            mem_q [MEM_BYTES];

  assign lat_clear = start_det | stop_det;
  assign lat_wr    = scl_fall && state_q == ST_WDATA && bit_q == 4'd8;
  assign commit    = stop_det && (|lat_valid);

  seep_page_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(lat_clear),
    .wr_i   (lat_wr),
    .idx_i  (addr_q[PW-1:0]),
    .data_i (sh_q),
    .data_o (lat_data),
    .valid_o(lat_valid)
  );

  seep_busy_timer #(.BUSY_CLKS(BUSY_CLKS)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit),
    .busy_o (busy)
  );

  // array stands in for the non-volatile cells: no reset
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit && lat_valid[i]) mem_q[{addr_q[AW-1:PW], PW'(i)}] <= lat_data[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pend_q  <= 1'b0;
      oe_q    <= 1'b0;
      hold_q  <= '0;
    end else if (start_det) begin
      state_q <= ST_CTRL;
      bit_q   <= '0;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (hold_q != '0) begin
        hold_q <= hold_q - HW'(1);
        if (hold_q == HW'(1)) oe_q <= pend_q;
      end
      if (scl_rise) begin
        unique case (state_q)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            sh_q  <= {sh_q[6:0], sda_f};
            bit_q <= bit_q + 4'd1;
          end
          ST_RDATA:     bit_q  <= bit_q + 4'd1;
          ST_RDATA_ACK: mack_q <= ~sda_f;
          default: ;
        endcase
      end
      if (scl_fall && state_q != ST_IDLE) begin
        hold_q <= HW'(HOLD_CLKS);
        unique case (state_q)
          ST_CTRL: if (bit_q == 4'd8) begin
            if (sh_q[7:4] == SEEP_DEV_ID && !busy) begin
              state_q <= ST_CTRL_ACK;
              rw_q    <= sh_q[0];
              pend_q  <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
              pend_q  <= 1'b0;
            end
          end
          ST_CTRL_ACK: begin
            bit_q <= '0;
            if (rw_q) begin
              state_q <= ST_RDATA;
              tx_q    <= mem_q[addr_q];
              pend_q  <= ~mem_q[addr_q][7];
            end else begin
              state_q <= ST_ADDR;
              pend_q  <= 1'b0;
            end
          end
          ST_ADDR: if (bit_q == 4'd8) begin
            addr_q  <= sh_q[AW-1:0];
            state_q <= ST_ADDR_ACK;
            pend_q  <= 1'b1;
          end
          ST_ADDR_ACK, ST_WDATA_ACK: begin
            state_q <= ST_WDATA;
            bit_q   <= '0;
            pend_q  <= 1'b0;
          end
          ST_WDATA: if (bit_q == 4'd8) begin
            addr_q[PW-1:0] <= addr_q[PW-1:0] + PW'(1);
            state_q        <= ST_WDATA_ACK;
            pend_q         <= 1'b1;
          end
          ST_RDATA: begin
            if (bit_q == 4'd8) begin
              state_q <= ST_RDATA_ACK;
              addr_q  <= addr_q + AW'(1);
              pend_q  <= 1'b0;
            end else begin
              pend_q <= ~tx_q[~bit_q[2:0]];
            end
          end
          ST_RDATA_ACK: begin
            if (mack_q) begin
              state_q <= ST_RDATA;
              bit_q   <= '0;
              tx_q    <= mem_q[addr_q];
              pend_q  <= ~mem_q[addr_q][7];
            end else begin
              state_q <= ST_IDLE;
              pend_q  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  // R9
  no_pull_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_f && scl_q |-> !$rose(oe_q));

  if (HOLD_CLKS > 1) begin : g_hold_chk
    // R9
    hold_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scl_fall |=> $stable(oe_q));
  end

  // R6
  no_ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CTRL_ACK |-> !busy);
endmodule

// File: tb/tb_seep_slave.sv
module tb_seep_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 16;
  localparam int FILT       = 3;
  localparam int HOLD       = 4;
  localparam int BUSY       = 1000;
  localparam int WD_CLKS    = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe256, oe128;
  logic line256, line128;
  bit   sel128 = 1'b0;
  bit   early_oe;

  assign line256 = m_sda & ~oe256;
  assign line128 = m_sda & ~oe128;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seep_slave #(.MEM_BYTES(256), .FILT_CLKS(FILT), .HOLD_CLKS(HOLD), .BUSY_CLKS(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(line256), .sda_oe_o(oe256));

  seep_slave #(.MEM_BYTES(128), .FILT_CLKS(FILT), .HOLD_CLKS(HOLD), .BUSY_CLKS(BUSY)) dut128 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(line128), .sda_oe_o(oe128));

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [256];
  bit         known [256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [300];

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic cur_line();
    return sel128 ? line128 : line256;
  endfunction

  task automatic start_c();
    clks(HALF / 2); m_sda = 1'b1; clks(HALF / 2);
    scl = 1'b1; clks(HALF);
    m_sda = 1'b0; clks(HALF);
    scl = 1'b0;
  endtask

  task automatic stop_c();
    clks(HALF / 2); m_sda = 1'b0; clks(HALF / 2);
    scl = 1'b1; clks(HALF);
    m_sda = 1'b1; clks(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      clks(HALF / 2); m_sda = b[i]; clks(HALF / 2);
      scl = 1'b1;
      if (gl && b[i]) begin
        clks(HALF / 2); m_sda = 1'b0; clks(2); m_sda = 1'b1; clks(HALF / 2 - 2);
      end else begin
        clks(HALF);
      end
      scl = 1'b0;
    end
    clks(HOLD);
    early_oe = sel128 ? oe128 : oe256;
    clks(HALF / 2 - HOLD); m_sda = 1'b1; clks(HALF / 2);
    scl = 1'b1; clks(HALF / 2);
    ack = ~cur_line();
    clks(HALF / 2); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      clks(HALF / 2); m_sda = 1'b1; clks(HALF / 2);
      scl = 1'b1; clks(HALF / 2);
      b[i] = cur_line();
      clks(HALF / 2); scl = 1'b0;
    end
    clks(HALF / 2); m_sda = ~mack; clks(HALF / 2);
    scl = 1'b1; clks(HALF); scl = 1'b0;
  endtask

  // write n bytes from wbuf at a; model wraps inside the 8-byte page
  task automatic wr_txn(input logic [7:0] a, input int n, input bit gl, output bit all_ack);
    bit ak;
    all_ack = 1'b1;
    start_c();
    send_byte(8'hA0, 1'b0, ak); all_ack &= ak;
    send_byte(a, 1'b0, ak);     all_ack &= ak;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], gl, ak); all_ack &= ak;
      exp_mem[{a[7:3], a[2:0] + 3'(i)}] = wbuf[i];
      known[{a[7:3], a[2:0] + 3'(i)}]   = 1'b1;
    end
    stop_c();
    clks(BUSY + 40);
  endtask

  task automatic rd_random(input logic [7:0] a, input int n);
    bit ak;
    start_c();
    send_byte(8'hA0, 1'b0, ak);
    send_byte(a, 1'b0, ak);
    start_c();
    send_byte(8'hA1, 1'b0, ak);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    stop_c();
  endtask

  task automatic rd_current(input int n);
    bit ak;
    start_c();
    send_byte(8'hA1, 1'b0, ak);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    stop_c();
  endtask

  initial begin
    clks(WD_CLKS);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] addrs [8];
    logic [7:0] old;
    for (int i = 0; i < 256; i++) known[i] = 1'b0;
    clks(5);
    rst_n = 1'b1;
    clks(5);

    // R1 reset state
    chk("R1 oe after reset", oe256, 0);
    chk("R1 oe128 after reset", oe128, 0);
    start_c(); send_byte(8'hA0, 1'b0, ak); stop_c();
    chk("R1 first ctrl acked", ak, 1);
    chk("R7 addr-less stop", oe256, 0);

    // R3 control decode
    start_c(); send_byte(8'hAE, 1'b0, ak);
    chk("R3 ctrl 1010_111_0 acked", ak, 1);
    send_byte(8'h20, 1'b0, ak);
    chk("R3 addr acked", ak, 1);
    stop_c();
    // R7 no write started: immediate poll is acked
    start_c(); send_byte(8'hA0, 1'b0, ak); stop_c();
    chk("R7 no busy after addr-only stop", ak, 1);
    start_c(); send_byte(8'hB0, 1'b0, ak);
    chk("R3 foreign ctrl nacked", ak, 0);
    send_byte(8'h00, 1'b0, ak);
    chk("R3 silent until next start", ak, 0);
    stop_c();

    // R4 byte write sweep
    addrs = '{8'h00, 8'h01, 8'h13, 8'h7F, 8'h80, 8'hC4, 8'hFE, 8'hFF};
    for (int k = 0; k < 8; k++) begin
      wbuf[0] = 8'(addrs[k] * 7 + 3);
      wr_txn(addrs[k], 1, 1'b0, ak);
      chk("R4 write acked", ak, 1);
    end
    for (int k = 0; k < 8; k++) begin
      rd_random(addrs[k], 1);
      chk("R4 random read", rbuf[0], exp_mem[addrs[k]]);
    end

    // R9 hold delay on an acked byte
    start_c();
    send_byte(8'hA0, 1'b0, ak);
    chk("R9 oe held after fall", early_oe, 0);
    chk("R9 ack present at rise", ak, 1);
    stop_c();

    // R5 page overrun: 10 bytes from offset 5
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'hA0 + i);
    wr_txn(8'h45, 10, 1'b0, ak);
    rd_random(8'h40, 8);
    for (int i = 0; i < 8; i++) chk("R5 page wrap", rbuf[i], exp_mem[8'h40 + i]);
    chk("R5 offset5 overwritten", exp_mem[8'h45], 8'hA8);

    // R6 busy window polling
    wbuf[0] = 8'h5C;
    start_c(); send_byte(8'hA0, 1'b0, ak); send_byte(8'h30, 1'b0, ak);
    send_byte(wbuf[0], 1'b0, ak); stop_c();
    exp_mem[8'h30] = 8'h5C; known[8'h30] = 1'b1;
    start_c(); send_byte(8'hA0, 1'b0, ak); stop_c();
    chk("R6 nack while busy", ak, 0);
    clks(BUSY);
    start_c(); send_byte(8'hA0, 1'b0, ak); stop_c();
    chk("R6 ack after busy", ak, 1);

    // R6 repeated START discards staged data, no busy
    start_c(); send_byte(8'hA0, 1'b0, ak); send_byte(8'h30, 1'b0, ak);
    send_byte(8'h11, 1'b0, ak);
    start_c(); send_byte(8'hA0, 1'b0, ak);
    chk("R6 no busy after aborted write", ak, 1);
    send_byte(8'h30, 1'b0, ak);
    start_c(); send_byte(8'hA1, 1'b0, ak);
    recv_byte(old, 1'b0); stop_c();
    chk("R6 aborted write not committed", old, 8'h5C);

    // R8 sequential wrap and current-address read
    rd_random(8'hFE, 3);
    chk("R8 seq FE", rbuf[0], exp_mem[8'hFE]);
    chk("R8 seq FF", rbuf[1], exp_mem[8'hFF]);
    chk("R8 seq wrap 00", rbuf[2], exp_mem[8'h00]);
    rd_current(1);
    chk("R8 current addr", rbuf[0], exp_mem[8'h01]);

    // R2 SDA glitch while SCL high
    wbuf[0] = 8'hFF;
    wr_txn(8'h12, 1, 1'b1, ak);
    chk("R2 glitch write acked", ak, 1);
    rd_random(8'h12, 1);
    chk("R2 glitch ignored", rbuf[0], 8'hFF);

    // R10 128-byte variant ignores address MSB
    wbuf[0] = 8'h3C;
    wr_txn(8'h85, 1, 1'b0, ak);
    sel128 = 1'b1;
    rd_random(8'h05, 1);
    chk("R10 msb ignored", rbuf[0], 8'h3C);
    sel128 = 1'b0;

    // R8 full-array sequential sweep against model
    rd_random(8'h00, 256);
    for (int i = 0; i < 256; i++)
      if (known[i]) chk("R8 sweep", rbuf[i], exp_mem[i]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule